// File: doc/BRIEF.md
# Static Memory Bus Sequencer

This block turns single read and write requests from an internal requester into timed cycles on an asynchronous parallel memory bus. The bus has six chip selects. Each one has its own pair of 32-bit timing words, a slow word and a fast word, presented as static inputs. A request carries a chip-select index, an address, write data and a direction flag. The block then runs a fixed sequence of phases on the bus: optional recovery, an address-valid strobe, optional address hold, a read setup gap, optional first-access latency, the strobe itself and, for writes, a hold tail. Each phase is skipped when its computed length is zero.

The address is presented only while the memory latches it: during the address-valid cycle and the optional hold cycle after it. Outside those cycles the address bus reads zero. Read data is sampled on the last output-enable cycle and returned with a single-cycle valid pulse. The block tracks the chip select and page of the last accepted access. It uses this to decide whether first-access latency applies, and whether the memory needs idle recovery cycles to release the data bus after a read.

Top module: `smem_seq`

## Requirements
- R1: Chip selects 0 to 5 are valid, and at most one of `mem_cs_n` is low at any time. A request with index 6 or 7 is consumed with `req_ready` staying high, and it starts no bus cycle.
- R2: `req_ready` goes low on the cycle after a request is accepted. It stays low for exactly recovery + 1 + address hold + read setup + latency + strobe + write hold cycles, where each term is as defined in R3 to R8.
- R3: The strobe (`mem_oe_n` low for reads, `mem_we_n` low for writes) lasts field + 1 cycles. The read field is slow[3:0] and the write field is slow[7:4].
- R4: Recovery takes slow[31:28] + 1 cycles with every chip select high, before the chip select is asserted. It is inserted only when the previous accepted access was a read and the new access is either to another chip select or is a write.
- R5: A write is followed by max(slow[27:24], 1) hold cycles. During these cycles the chip select stays low, `mem_we_n` is high and `mem_dout_en` stays high.
- R6: First-access latency adds slow[15:8] cycles (reads) or slow[23:16] cycles (writes) between the address phase and the strobe. It applies only when the chip select or the page (address bits above PAGE_BITS) differs from the previous accepted access, or when the access is the first one after reset.
- R7: On reads only, fast[27:24] + fast[17:16] setup cycles are placed between the address phase and the strobe.
- R8: When fast[5] is set, one extra cycle follows the address-valid cycle. In that cycle the address is still driven and `mem_adv_n` is high.
- R9: `mem_adv_n` is low for exactly one cycle, and that cycle is the first cycle of chip-select assertion. `mem_addr` carries the request address only during the address cycles and is zero at all other times.
- R10: For a read, the value on `mem_din` during the last `mem_oe_n`-low cycle is returned on `rsp_rdata`, with `rsp_valid` high for one cycle in the cycle right after the strobe.
- R11: After reset, all strobes and chip selects are high and `mem_dout_en` is low. `mem_dout_en` is high only during the write strobe and the write hold. `mem_oe_n` and `mem_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CSW | Chip-select index |
| req_addr | input | AW | Memory address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | DW | Read data |
| slow_cfg | input | NCS*32 | Per-select slow timing words, select i at bits 32i+31:32i |
| fast_cfg | input | NCS*32 | Per-select fast timing words, same packing |
| mem_cs_n | output | NCS | Chip selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_addr | output | AW | Address to memory |
| mem_dout | output | DW | Write data to memory |
| mem_dout_en | output | 1 | Write data drive enable |
| mem_din | input | DW | Read data from memory |

## Verification
The properties assume that the requester only raises a request while it is ready to have it consumed, and that the timing words are stable while a request is in flight. The bench follows both assumptions: it changes the timing words only between requests, while `req_ready` is high, and it holds `req_valid` for exactly one accepting edge. The random stimulus picks addresses from a few pages, so that both page hits and page misses occur. It also mixes in invalid chip-select indices.

// File: rtl/smem_seq.sv
module smem_seq #(
  parameter int NCS       = 6,
  parameter int CSW       = 3,
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int PAGE_BITS = 4,
  parameter int CNTW      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [NCS*32-1:0] slow_cfg,
  input  logic [NCS*32-1:0] fast_cfg,
  output logic [NCS-1:0]    mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_dout_en,
  input  logic [DW-1:0]     mem_din
);
  localparam int PW = AW - PAGE_BITS;
  localparam logic [CNTW-1:0] ONE = CNTW'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_RCV, S_ADV, S_AHLD, S_PRE, S_LAT, S_STB, S_WHLD
  } st_t;

  st_t st, nst;
  logic [CNTW-1:0] cnt, ncnt;
  logic [CNTW-1:0] plen [8];

  logic            w_q, first_q, rcv_q;
  logic [CSW-1:0]  cs_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [31:0]     slow_q, fast_q;

  logic            last_rd, pg_ok;
  logic [CSW-1:0]  last_cs;
  logic [PW-1:0]   last_pg;

  logic            cs_ok, accept, req_first, req_rcv, nbus, strobe_end;
  logic            f_w, f_first, f_rcv;
  logic [CSW-1:0]  f_cs;
  logic [AW-1:0]   f_addr;
  logic [DW-1:0]   f_wdata;
  logic [31:0]     f_slow, f_fast;

  assign req_ready = (st == S_IDLE);
  assign cs_ok     = int'({1'b0, req_cs}) < NCS;
  assign accept    = req_valid && req_ready && cs_ok;
  assign req_first = !pg_ok || (req_cs != last_cs) || (req_addr[AW-1:PAGE_BITS] != last_pg);
  assign req_rcv   = last_rd && ((req_cs != last_cs) || req_write);

  assign f_w     = accept ? req_write : w_q;
  assign f_cs    = accept ? req_cs : cs_q;
  assign f_addr  = accept ? req_addr : addr_q;
  assign f_wdata = accept ? req_wdata : wdata_q;
  assign f_slow  = accept ? slow_cfg[32'(req_cs)*32 +: 32] : slow_q;
  assign f_fast  = accept ? fast_cfg[32'(req_cs)*32 +: 32] : fast_q;
  assign f_first = accept ? req_first : first_q;
  assign f_rcv   = accept ? req_rcv : rcv_q;

  always_comb begin
    plen[S_IDLE] = '0;
    plen[S_RCV]  = f_rcv ? CNTW'(f_slow[31:28]) + ONE : '0;
    plen[S_ADV]  = ONE;
    plen[S_AHLD] = CNTW'(f_fast[5]);
    plen[S_PRE]  = f_w ? '0 : CNTW'(f_fast[27:24]) + CNTW'(f_fast[17:16]);
    plen[S_LAT]  = f_first ? CNTW'(f_w ? f_slow[23:16] : f_slow[15:8]) : '0;
    plen[S_STB]  = CNTW'(f_w ? f_slow[7:4] : f_slow[3:0]) + ONE;
    plen[S_WHLD] = !f_w ? '0 : (f_slow[27:24] == 4'd0 ? ONE : CNTW'(f_slow[27:24]));
  end

  always_comb begin
    int   base;
    logic scan, found;
    nst   = st;
    ncnt  = cnt;
    base  = 0;
    scan  = 1'b0;
    found = 1'b0;
    if (st == S_IDLE) scan = accept;
    else if (cnt != '0) ncnt = cnt - ONE;
    else begin
      scan = 1'b1;
      base = int'(st);
    end
    if (scan) begin
      nst  = S_IDLE;
      ncnt = '0;
      for (int k = 1; k < 8; k++) begin
        if (!found && k > base && plen[k] != '0) begin
          nst   = st_t'(3'(k));
          ncnt  = plen[k] - ONE;
          found = 1'b1;
        end
      end
    end
  end

  assign nbus       = (nst != S_IDLE) && (nst != S_RCV);
  assign strobe_end = (st == S_STB) && (cnt == '0) && !w_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      w_q         <= 1'b0;
      first_q     <= 1'b0;
      rcv_q       <= 1'b0;
      cs_q        <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      slow_q      <= '0;
      fast_q      <= '0;
      last_rd     <= 1'b0;
      pg_ok       <= 1'b0;
      last_cs     <= '0;
      last_pg     <= '0;
      mem_cs_n    <= '1;
      mem_oe_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_adv_n   <= 1'b1;
      mem_addr    <= '0;
      mem_dout    <= '0;
      mem_dout_en <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      st  <= nst;
      cnt <= ncnt;
      if (accept) begin
        w_q     <= req_write;
        cs_q    <= req_cs;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        slow_q  <= f_slow;
        fast_q  <= f_fast;
        first_q <= req_first;
        rcv_q   <= req_rcv;
        last_rd <= !req_write;
        last_cs <= req_cs;
        last_pg <= req_addr[AW-1:PAGE_BITS];
        pg_ok   <= 1'b1;
      end
      mem_cs_n    <= nbus ? ~(NCS'(1) << f_cs) : '1;
      mem_adv_n   <= (nst != S_ADV);
      mem_oe_n    <= !((nst == S_STB) && !f_w);
      mem_we_n    <= !((nst == S_STB) && f_w);
      mem_addr    <= (nst == S_ADV || nst == S_AHLD) ? f_addr : '0;
      mem_dout_en <= f_w && (nst == S_STB || nst == S_WHLD);
      mem_dout    <= f_wdata;
      rsp_valid   <= strobe_end;
      if (strobe_end) rsp_rdata <= mem_din;
    end
  end
endmodule

// File: rtl/smem_seq_chk.sv
module smem_seq_chk #(
  parameter int NCS = 6,
  parameter int CSW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [CSW-1:0] req_cs,
  input logic [NCS-1:0] mem_cs_n,
  input logic           mem_oe_n,
  input logic           mem_we_n,
  input logic           mem_adv_n,
  input logic           mem_dout_en,
  input logic           rsp_valid
);
  a_r1_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  a_r1_bad_index_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && int'({1'b0, req_cs}) >= NCS) |=> (&mem_cs_n && req_ready));

  a_r2_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !(&mem_cs_n) |-> !req_ready);

  a_r3_strobe_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

  a_r9_adv_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (!(&mem_cs_n) && mem_oe_n && mem_we_n));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r10_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n));

  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r11_drive_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> (mem_oe_n && !(&mem_cs_n)));
endmodule

bind smem_seq smem_seq_chk #(.NCS(NCS), .CSW(CSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_cs(req_cs), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_adv_n(mem_adv_n), .mem_dout_en(mem_dout_en), .rsp_valid(rsp_valid)
);

// File: tb/smem_seq_bench.sv
`timescale 1ns/1ps
module smem_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_cs = '0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [191:0] slow_cfg, fast_cfg;
  logic [5:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n, mem_adv_n, mem_dout_en;
  logic [15:0] mem_addr, mem_dout;
  logic [15:0] mem_din = '0;

  logic [31:0] slow [6];
  logic [31:0] fast [6];
  int n_chk = 0, n_fail = 0;
  bit m_rd = 0, m_ok = 0;
  int m_cs = 0;
  logic [11:0] m_pg = '0;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < 6; i++) begin
      slow_cfg[i*32 +: 32] = slow[i];
      fast_cfg[i*32 +: 32] = fast[i];
    end

  smem_seq u_smem_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .slow_cfg(slow_cfg), .fast_cfg(fast_cfg),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int strobe_len(input logic [31:0] sl, input bit w);
    return w ? int'(sl[7:4]) + 1 : int'(sl[3:0]) + 1;
  endfunction

  function automatic int hold_len(input logic [31:0] sl, input bit w);
    if (!w) return 0;
    return (sl[27:24] == 0) ? 1 : int'(sl[27:24]);
  endfunction

  // called at a falling edge with req_ready high
  task automatic xfer(input bit w, input int cs, input logic [15:0] a,
                      input logic [15:0] wd, input logic [15:0] din);
    logic [31:0] sl = slow[cs];
    logic [31:0] fa = fast[cs];
    bit first = !m_ok || cs != m_cs || a[15:4] != m_pg;
    bit rc = m_rd && (cs != m_cs || w);
    int er = rc ? int'(sl[31:28]) + 1 : 0;
    int eah = int'(fa[5]);
    int epre = w ? 0 : int'(fa[27:24]) + int'(fa[17:16]);
    int elat = first ? (w ? int'(sl[23:16]) : int'(sl[15:8])) : 0;
    int estb = strobe_len(sl, w);
    int ewh = hold_len(sl, w);
    int ebusy = er + 1 + eah + epre + elat + estb + ewh;
    int busy = 0, lead = 0, csl = 0, badcs = 0, oe = 0, we = 0, adv = 0, advpos = 0;
    int acnt = 0, abad = 0, den = 0, pre = -1, rv = 0, rbad = 0;
    chk(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
    req_write = w; req_cs = 3'(cs); req_addr = a; req_wdata = wd; mem_din = din;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && busy < 2000) begin
      busy++;
      if (&mem_cs_n) begin
        if (csl == 0) lead++;
      end else begin
        csl++;
        if (mem_cs_n != ~(6'b1 << cs)) badcs++;
        if (!mem_adv_n) begin adv++; advpos = csl; end
        if (pre < 0 && (!mem_oe_n || !mem_we_n)) pre = csl - 1;
      end
      if (!mem_oe_n) oe++;
      if (!mem_we_n) we++;
      if (mem_dout_en) begin
        den++;
        if (mem_dout != wd) abad++;
      end
      if (mem_addr != 16'd0) begin
        acnt++;
        if (mem_addr != a) abad++;
      end
      if (rsp_valid) rv++;
      @(negedge clk);
    end
    if (rsp_valid) begin
      rv++;
      if (rsp_rdata != din) rbad++;
    end
    chk(busy == ebusy, "R2 busy length", busy, ebusy);
    chk(lead == er, "R4 recovery cycles", lead, er);
    chk(badcs == 0 && csl == ebusy - er, "R1 select held", csl, ebusy - er);
    chk(adv == 1 && advpos == 1, "R9 adv first cycle", adv * 10 + advpos, 11);
    chk(acnt == 1 + eah && abad == 0, "R8 R9 address cycles", acnt, 1 + eah);
    chk(pre == 1 + eah + epre + elat, "R6 R7 R8 strobe offset", pre, 1 + eah + epre + elat);
    chk(w ? (we == estb && oe == 0) : (oe == estb && we == 0), "R3 strobe width",
        w ? we : oe, estb);
    chk(den == (w ? estb + ewh : 0), "R5 R11 drive and hold", den, w ? estb + ewh : 0);
    chk(rv == (w ? 0 : 1) && rbad == 0, "R10 read return", rv + 10 * rbad, w ? 0 : 1);
    m_rd = !w; m_cs = cs; m_pg = a[15:4]; m_ok = 1'b1;
  endtask

  task automatic bad_req(input int cs);
    int bad = 0;
    req_cs = 3'(cs); req_write = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (!req_ready || !(&mem_cs_n) || !mem_oe_n || !mem_adv_n) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R1 invalid index ignored", bad, 0);
  endtask

  initial begin
    #1_900_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    slow[0] = 32'h2005_0712; fast[0] = 32'h0000_0000;
    slow[1] = 32'h3200_0304; fast[1] = 32'h0402_0020;
    slow[2] = 32'h0F10_0A00; fast[2] = 32'h0000_0000;
    slow[3] = 32'hFFFF_FFFF; fast[3] = 32'h0F03_0020;
    slow[4] = 32'h0000_0000; fast[4] = 32'h0000_0000;
    slow[5] = 32'h1111_1111; fast[5] = 32'h0001_0000;
    repeat (3) @(negedge clk);
    chk(&mem_cs_n && mem_oe_n && mem_we_n && mem_adv_n && !mem_dout_en && !rsp_valid,
        "R11 reset outputs", int'(mem_cs_n), 63);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && &mem_cs_n, "R11 idle after reset", int'(req_ready), 1);

    xfer(0, 0, 16'h0011, 16'h0000, 16'hA5A5);
    xfer(0, 0, 16'h0013, 16'h0000, 16'h5A5A);
    xfer(1, 0, 16'h0015, 16'h1234, 16'h0000);
    xfer(1, 0, 16'h0025, 16'h4321, 16'h0000);
    xfer(0, 1, 16'h0101, 16'h0000, 16'hBEEF);
    xfer(1, 2, 16'h0201, 16'hCAFE, 16'h0000);
    xfer(0, 3, 16'h0301, 16'h0000, 16'hFFFF);
    xfer(0, 4, 16'h0001, 16'h0000, 16'h0001);
    xfer(1, 4, 16'h0003, 16'h7777, 16'h0000);
    bad_req(6);
    bad_req(7);
    xfer(0, 5, 16'h0501, 16'h0000, 16'h1357);
    xfer(0, 5, 16'h0507, 16'h0000, 16'h2468);

    for (int n = 0; n < 400; n++) begin
      int cs;
      if (n % 50 == 0)
        for (int i = 0; i < 6; i++) begin
          slow[i] = $urandom & 32'hFF1F_1FFF;
          fast[i] = $urandom;
        end
      cs = int'($urandom % 7);
      if (cs == 6) bad_req(6 + int'($urandom % 2));
      else xfer(1'($urandom), cs,
                16'((($urandom % 3) << 4) | ($urandom % 16) | 1),
                16'($urandom), 16'($urandom));
      if ($urandom % 4 == 0) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule